// File: doc/BRIEF.md
# Serial Peripheral Port with Master/Slave Operation and Contention Detection

This block is a byte-wide full-duplex serial port. A control bit makes it the bus master or a slave. Every transfer moves one byte out and one byte in at the same time through a single shift register. The most significant bit goes first. The serial clock idles low. The outgoing bit changes on the falling clock edge, and the incoming bit is sampled on the rising edge.

As master, the block makes the serial clock from the system clock. The divide ratio is 2, 4, 16 or 32, chosen by a rate field. It also watches its active-low select pin. If another device pulls that pin low, the block reports a mode fault and leaves master mode.

As slave, the block takes part only while its select pin is low. Otherwise its data output is not driven and the incoming clock and data are ignored. Software reaches the block through three registers (control, status, data) and one interrupt line. A received byte is copied into a read buffer, so software never reads the live shifter.

Top module: `spi_port`

## Requirements
- R1: As master, a data-register write sends the byte on the MOSI output, MSB first. The byte gathered from MISO, MSB first, is then readable at data address 2.
- R2: Control bits [4:3] select the SCK period: 0 gives 2 system clocks, 1 gives 4, 2 gives 16 and 3 gives 32. SCK is low whenever the port does not drive it.
- R3: While the select input is high, or the port is not an enabled slave, miso_oe is 0. Clock and data toggles on the slave pins then set no flag and leave the read buffer unchanged.
- R4: As an enabled slave (control bit0=1, bit1=0) with select low, the port shifts the preloaded byte out on MISO MSB first. It stores the byte clocked in on the slave data input.
- R5: With control bit0 (enable) and bit1 (master) both set, a low select input sets status bit2 (mode fault). It also clears both control bits and drops sck_oe and mosi_oe.
- R6: The mode-fault flag clears only when a status read that sees it set is followed by a control write. A control write without that read leaves it set.
- R7: Status bit0 (done) is set after the eighth bit. It is cleared by a status read that sees it, followed by a data-register read or write. A data read without the status read first does not clear it.
- R8: A data-register write during a transfer sets status bit1 (write collision) and does not change the byte being shifted out.
- R9: irq is 1 exactly when control bit2 (interrupt enable) is 1 and at least one status flag is set.
- R10: A data write starts a master transfer only when both enable and master control bits are 1; otherwise no SCK edge appears.
- R11: After reset, control and status read 0, and sck_oe, mosi_oe, miso_oe and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data input (slave) |
| mosi_o | output | 1 | Serial data output (master) |
| mosi_oe | output | 1 | Master data output enable |
| miso_i | input | 1 | Serial data input (master) |
| miso_o | output | 1 | Serial data output (slave) |
| miso_oe | output | 1 | Slave data output enable |
| ss_n_i | input | 1 | Active-low select / contention input |

## Verification
The bench builds the port with the default byte width of 8 and the default two-stage pin synchronizer. It then drives every value of the rate field, which covers both the single-cycle half period of divide-by-2 and the sixteen-cycle half period of divide-by-32. The slow divide gives the bench a wide window to land a colliding write in the middle of a transfer. The slave pins are driven several cycles per phase, well within the reach of the synchronizer.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
    localparam int MAX_DIV   = 32;
    localparam int DIV_CNT_W = $clog2(MAX_DIV / 2);

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic [1:0] rate;
        logic       ie;
        logic       mst;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic int unsigned half_period(input logic [1:0] rate);
        case (rate)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 8;
            default: return 16;
        endcase
    endfunction
endpackage

// File: rtl/spi_port_clkdiv.sv
`timescale 1ns/1ps
module spi_port_clkdiv
    import spi_port_pkg::*;
#(
    parameter int CNT_W = DIV_CNT_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim   = CNT_W'(half_period(rate) - 1);
        tick  = run && (cnt_q == lim);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_port_sync.sv
`timescale 1ns/1ps
module spi_port_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
        dout = pipe_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i
);
    localparam int BIT_W = $clog2(DATA_W);

    typedef struct packed {
        ctrl_t             ctrl;
        logic              done;
        logic              wcol;
        logic              fault;
        logic              done_arm;
        logic              fault_arm;
        logic              busy;
        logic              sck;
        logic              samp;
        logic              sck_prev;
        logic [BIT_W-1:0]  bitcnt;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] rxbuf;
    } state_t;

    state_t s_d, s_q;
    logic   tick;
    logic   ss_s, sck_s, mosi_s;
    logic   sel_lo, slave_act, xfer_act;
    logic   stat_rd, data_acc, ctrl_wr, data_wr;
    logic   s_rise, s_fall;
    ctrl_t  ctrl_new;

    spi_port_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ss_n_i, sck_i, mosi_i}),
        .dout ({ss_s, sck_s, mosi_s})
    );

    spi_port_clkdiv u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (s_q.busy),
        .rate (s_q.ctrl.rate),
        .tick (tick)
    );

    always_comb begin
        s_d       = s_q;
        sel_lo    = !ss_s;
        slave_act = s_q.ctrl.en && !s_q.ctrl.mst && sel_lo;
        xfer_act  = s_q.busy || slave_act;
        stat_rd   = reg_rd && (reg_sel == REG_STAT);
        data_acc  = (reg_rd || reg_wr) && (reg_sel == REG_DATA);
        ctrl_wr   = reg_wr && (reg_sel == REG_CTRL);
        data_wr   = reg_wr && (reg_sel == REG_DATA);
        s_rise    = sck_s && !s_q.sck_prev;
        s_fall    = !sck_s && s_q.sck_prev;
        ctrl_new  = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        s_d.sck_prev = sck_s;

        // flag clearing sequences
        if (stat_rd) begin
            if (s_q.done || s_q.wcol) s_d.done_arm  = 1'b1;
            if (s_q.fault)            s_d.fault_arm = 1'b1;
        end
        if (data_acc && s_q.done_arm) begin
            s_d.done     = 1'b0;
            s_d.wcol     = 1'b0;
            s_d.done_arm = 1'b0;
        end

        if (ctrl_wr) begin
            s_d.ctrl = ctrl_new;
            if (s_q.fault_arm) begin
                s_d.fault     = 1'b0;
                s_d.fault_arm = 1'b0;
            end
            if (!(ctrl_new.en && ctrl_new.mst)) begin
                s_d.busy   = 1'b0;
                s_d.sck    = 1'b0;
            end
        end

        if (!slave_act && !s_q.busy) s_d.bitcnt = '0;

        if (data_wr) begin
            if (xfer_act) begin
                s_d.wcol = 1'b1;
            end else begin
                s_d.shreg = reg_wdata;
                if (s_q.ctrl.en && s_q.ctrl.mst) begin
                    s_d.busy   = 1'b1;
                    s_d.sck    = 1'b0;
                    s_d.bitcnt = '0;
                end
            end
        end

        // master engine: sample on rising SCK, shift on falling SCK
        if (s_q.busy && tick) begin
            if (!s_q.sck) begin
                s_d.sck  = 1'b1;
                s_d.samp = miso_i;
            end else begin
                s_d.sck    = 1'b0;
                s_d.shreg  = {s_q.shreg[DATA_W-2:0], s_q.samp};
                s_d.bitcnt = s_q.bitcnt + 1'b1;
                if (s_q.bitcnt == BIT_W'(DATA_W - 1)) begin
                    s_d.busy   = 1'b0;
                    s_d.rxbuf  = {s_q.shreg[DATA_W-2:0], s_q.samp};
                    s_d.done   = 1'b1;
                    s_d.bitcnt = '0;
                end
            end
        end

        // slave engine on synchronised pins
        if (slave_act) begin
            if (s_rise) s_d.samp = mosi_s;
            if (s_fall) begin
                s_d.shreg  = {s_q.shreg[DATA_W-2:0], s_q.samp};
                s_d.bitcnt = s_q.bitcnt + 1'b1;
                if (s_q.bitcnt == BIT_W'(DATA_W - 1)) begin
                    s_d.rxbuf  = {s_q.shreg[DATA_W-2:0], s_q.samp};
                    s_d.done   = 1'b1;
                    s_d.bitcnt = '0;
                end
            end
        end

        // contention: another master pulled our select low
        if (s_q.ctrl.en && s_q.ctrl.mst && sel_lo) begin
            s_d.fault     = 1'b1;
            s_d.fault_arm = 1'b0;
            s_d.ctrl.en   = 1'b0;
            s_d.ctrl.mst  = 1'b0;
            s_d.busy      = 1'b0;
            s_d.sck       = 1'b0;
            s_d.bitcnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        sck_o   = s_q.sck;
        sck_oe  = s_q.ctrl.en && s_q.ctrl.mst;
        mosi_o  = s_q.shreg[DATA_W-1];
        mosi_oe = s_q.ctrl.en && s_q.ctrl.mst;
        miso_o  = s_q.shreg[DATA_W-1];
        miso_oe = slave_act;
        irq     = s_q.ctrl.ie && (s_q.done || s_q.wcol || s_q.fault);
        case (reg_sel)
            REG_CTRL: reg_rdata = DATA_W'(s_q.ctrl);
            REG_STAT: reg_rdata = DATA_W'({s_q.fault, s_q.wcol, s_q.done});
            REG_DATA: reg_rdata = s_q.rxbuf;
            default:  reg_rdata = '0;
        endcase
    end

    logic flag_done, flag_wcol, flag_fault, ctrl_ie;
    assign flag_done  = s_q.done;
    assign flag_wcol  = s_q.wcol;
    assign flag_fault = s_q.fault;
    assign ctrl_ie    = s_q.ctrl.ie;
endmodule

// File: rtl/spi_port_chk.sv
`timescale 1ns/1ps
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_sel,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       miso_oe,
    input logic       irq,
    input logic       flag_done,
    input logic       flag_wcol,
    input logic       flag_fault,
    input logic       ctrl_ie
);
    AST_SCK_PARKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_oe |-> !sck_o);                                                  // R2
    AST_NO_DRIVE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        sck_oe |-> !miso_oe);                                                 // R3
    AST_FAULT_RELEASES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_fault) |-> (!sck_oe && !mosi_oe));                         // R5
    AST_DONE_CLEAR_BY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_done) |-> $past((reg_rd || reg_wr) && reg_sel == 2'd2));  // R7
    AST_WCOL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_wcol) |-> $past(reg_wr && reg_sel == 2'd2));              // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_ie);                                                     // R9
endmodule

bind spi_port spi_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .sck_o     (sck_o),
    .sck_oe    (sck_oe),
    .mosi_oe   (mosi_oe),
    .miso_oe   (miso_oe),
    .irq       (irq),
    .flag_done (flag_done),
    .flag_wcol (flag_wcol),
    .flag_fault(flag_fault),
    .ctrl_ie   (ctrl_ie)
);

// File: tb/spi_port_test.sv
`timescale 1ns/1ps
module spi_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

    int errors = 0, checks = 0;
    int cyc = 0, rise_cyc = 0, per_last = 0, rises = 0, ncap = 0;
    logic [7:0] sb = 8'h00, cap = 8'h00;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    spi_port uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_sel = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    // driver: queue the byte expected on MOSI, load the bench slave, start
    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sval, input int div);
        sb = sval; miso_i = sval[7];
        exp_q.push_back(tx);
        bus_wr(2'd2, tx);
        repeat (8 * div + 10) @(negedge clk);
    endtask

    // bench slave model driven by the master clock
    always @(negedge sck_o) begin
        sb = {sb[6:0], 1'b0};
        miso_i = sb[7];
    end

    // monitor: collect MOSI bits, compare with the scoreboard, time SCK
    always @(posedge sck_o) begin
        rises++;
        per_last = cyc - rise_cyc;
        rise_cyc = cyc;
        cap = {cap[6:0], mosi_o};
        ncap++;
        if (ncap == 8) begin
            ncap = 0;
            if (exp_q.size() == 0) chk("R1 mosi unexpected byte", cap, 32'hFFFF_FFFF);
            else                   chk("R1 mosi byte", cap, exp_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11 reset state
        bus_rd(2'd0, d); chk("R11 ctrl", d, 8'h00);
        bus_rd(2'd1, d); chk("R11 status", d, 8'h00);
        chk("R11 outputs", {sck_oe, mosi_oe, miso_oe, irq}, 4'b0000);

        // R10 no start unless enabled master
        r0 = rises;
        bus_wr(2'd0, 8'h02);            // master, not enabled
        bus_wr(2'd2, 8'h55);
        repeat (40) @(negedge clk);
        chk("R10 no sck when disabled", rises, r0);
        bus_wr(2'd0, 8'h01);            // enabled slave, select high
        bus_wr(2'd2, 8'h55);
        repeat (40) @(negedge clk);
        chk("R10 no sck as slave", rises, r0);
        bus_rd(2'd1, d); chk("R10 no done", d[0], 1'b0);

        // R1 / R2 master transfers at each rate
        bus_wr(2'd0, 8'h03);
        master_xfer(8'hA5, 8'h3C, 2);
        chk("R2 period div2", per_last, 2);
        chk("R9 irq masked", irq, 1'b0);
        bus_rd(2'd2, d); chk("R1 rx div2", d, 8'h3C);
        bus_rd(2'd1, d); chk("R7 done kept after data read alone", d[0], 1'b1);
        bus_rd(2'd2, d);
        bus_rd(2'd1, d); chk("R7 done cleared", d[0], 1'b0);

        bus_wr(2'd0, 8'h0B);
        master_xfer(8'h81, 8'h7E, 4);
        chk("R2 period div4", per_last, 4);
        bus_rd(2'd1, d); chk("R7 done set", d[0], 1'b1);
        bus_rd(2'd2, d); chk("R1 rx div4", d, 8'h7E);

        bus_wr(2'd0, 8'h13);
        master_xfer(8'h5A, 8'hC3, 16);
        chk("R2 period div16", per_last, 16);
        bus_rd(2'd1, d);
        bus_rd(2'd2, d); chk("R1 rx div16", d, 8'hC3);
        chk("R2 sck idle low", sck_o, 1'b0);

        // R8 collision at divide 32
        bus_wr(2'd0, 8'h1B);
        sb = 8'h96; miso_i = 1'b1;
        exp_q.push_back(8'hF0);
        bus_wr(2'd2, 8'hF0);
        repeat (20) @(negedge clk);
        bus_wr(2'd2, 8'h0F);
        bus_rd(2'd1, d); chk("R8 wcol set", d[1], 1'b1);
        repeat (8 * 32 + 10) @(negedge clk);
        chk("R2 period div32", per_last, 32);
        bus_rd(2'd1, d);
        bus_rd(2'd2, d); chk("R8 rx intact", d, 8'h96);
        bus_rd(2'd1, d); chk("R8 wcol cleared", d[1:0], 2'b00);

        // R9 interrupt
        bus_wr(2'd0, 8'h0F);
        master_xfer(8'h3C, 8'hFF, 4);
        chk("R9 irq on done", irq, 1'b1);
        bus_rd(2'd1, d);
        bus_rd(2'd2, d);
        @(negedge clk);
        chk("R9 irq cleared", irq, 1'b0);

        // R5 / R6 mode fault
        bus_wr(2'd0, 8'h03);
        ss_n_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R5 pins released", {sck_oe, mosi_oe}, 2'b00);
        bus_rd(2'd0, d); chk("R5 ctrl cleared", d[1:0], 2'b00);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_wr(2'd0, 8'h03);
        bus_rd(2'd1, d); chk("R6 fault held without status read", d[2], 1'b1);
        bus_wr(2'd0, 8'h03);
        bus_rd(2'd1, d); chk("R6 fault cleared", d[2], 1'b0);

        // R3 unselected slave ignores pins
        bus_wr(2'd0, 8'h01);
        bus_wr(2'd2, 8'h3C);
        chk("R3 miso idle", miso_oe, 1'b0);
        mosi_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            repeat (6) @(negedge clk); sck_i = 1'b1;
            repeat (6) @(negedge clk); sck_i = 1'b0;
        end
        repeat (6) @(negedge clk);
        bus_rd(2'd1, d); chk("R3 no done", d[0], 1'b0);
        bus_rd(2'd2, d); chk("R3 buffer unchanged", d, 8'hFF);

        // R4 selected slave exchange
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        chk("R4 miso driven", miso_oe, 1'b1);
        cap = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            mosi_i = logic'((8'hA5 >> i) & 1);
            repeat (6) @(negedge clk);
            cap = {cap[6:0], miso_o};
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (6) @(negedge clk);
        ss_n_i = 1'b1;
        chk("R4 miso byte", cap, 8'h3C);
        bus_rd(2'd1, d); chk("R4 done", d[0], 1'b1);
        bus_rd(2'd2, d); chk("R4 rx", d, 8'hA5);

        chk("R1 scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule